// File: doc/BRIEF.md
# Word Serializer with Falling-Edge Clock Hold

This block turns a parallel word into a serial stream with the most significant bit first. It sends one bit on each active rising clock edge. A registered frame clock runs next to the stream. It is high for the first half of each word and low for the second half. A downstream receiver can use it to find word boundaries. An upstream source can use it as the trigger to present the next word. The block captures the word on the edge that starts the word, so the source must hold the word stable only around that edge.

A hold request is registered on the falling edge of the clock. From the next rising edge on, the counter, the shift register and both outputs freeze as whole bit times, so no pulse is ever cut short. When the request is dropped, the next falling edge releases the block. It then continues from the exact bit where it stopped. A synchronous reset and a sync input both clear the framing, so the next active edge begins a fresh word.

Top module: `word_serializer`

## Requirements
- R1: While `rst` is high at a rising edge, `ser_out` and `frame_clk` go to 0, and the internal hold is released.
- R2: On the first active rising edge after a reset or sync, the block captures `par_data`, and `ser_out` takes `par_data[7]`.
- R3: On each active rising edge, one bit leaves the block, most significant bit first. A word takes 8 active edges. The edge after bit 0 captures the next word with no gap.
- R4: `frame_clk` is 1 during bit times 0 to 3 of each word (bits 7 down to 4) and 0 during bit times 4 to 7.
- R5: `hold_req` is sampled on the falling edge. At each rising edge that follows a falling edge that saw it at 1, `ser_out`, `frame_clk` and the bit position stay unchanged.
- R6: After a falling edge sees `hold_req` at 0 again, the next rising edge sends the bit that follows the last one sent. No bit is lost and none is repeated.
- R7: A high `sync_i` at a rising edge clears the bit position and drives both outputs to 0, even during a hold. The next active edge starts a new word.
- R8: Changes on `par_data` during bit times 1 to 7 have no effect on the serial output of the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Synchronous framing restart |
| hold_req | input | 1 | Suspend request, sampled on the falling edge |
| par_data | input | 8 | Parallel word, captured at the start of each word |
| ser_out | output | 1 | Serial data, most significant bit first |
| frame_clk | output | 1 | Word-frame clock, high for the first half of each word |

## Verification
The assertions assume that `hold_req` settles well clear of the falling edge, and that `rst`, `sync_i` and `par_data` settle well clear of the rising edge. The stimulus changes every input a short time after each rising edge. That keeps it away from both sampling edges. The random mix drives holds often and syncs rarely. It also changes `par_data` on every cycle, so words that are captured in the middle of a hold, and data that moves in the middle of a word, both occur.

// File: rtl/word_serializer_pkg.sv
package word_serializer_pkg;
  localparam int unsigned DEF_WORD_W = 8;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_HOLD  = 2'd1,
    ST_STEP  = 2'd2
  } ser_op_e;
endpackage

// File: rtl/ws_hold_sync.sv
module ws_hold_sync (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  output logic hold_q
);
  always_ff @(negedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= hold_req;
  end
endmodule

// File: rtl/ws_bit_counter.sv
module ws_bit_counter
  import word_serializer_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ser_op_e                   op,
  output logic [$clog2(WORD_W)-1:0] bit_pos,
  output logic                      frame_clk
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

  always_ff @(posedge clk) begin
    case (op)
      ST_CLEAR: begin
        bit_pos   <= '0;
        frame_clk <= 1'b0;
      end
      ST_STEP: begin
        bit_pos   <= (bit_pos == LAST) ? '0 : bit_pos + 1'b1;
        frame_clk <= (bit_pos < HALF);
      end
      default: ;
    endcase
  end

  assert_frame_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (op == ST_STEP && bit_pos == '0) |=> frame_clk);
  assert_frame_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (op == ST_STEP && bit_pos == HALF) |=> !frame_clk);
  assert_clear_pos_R7: assert property (@(posedge clk)
    (op == ST_CLEAR) |=> (bit_pos == '0 && !frame_clk));
  assert_hold_pos_R5: assert property (@(posedge clk) disable iff (rst)
    (op == ST_HOLD) |=> ($stable(bit_pos) && $stable(frame_clk)));
endmodule

// File: rtl/ws_shifter.sv
module ws_shifter
  import word_serializer_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ser_op_e           op,
  input  logic              first_bit,
  input  logic [WORD_W-1:0] par_data,
  output logic              ser_out
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    case (op)
      ST_CLEAR: begin
        shreg   <= '0;
        ser_out <= 1'b0;
      end
      ST_STEP: begin
        if (first_bit) begin
          ser_out <= par_data[WORD_W-1];
          shreg   <= par_data << 1;
        end else begin
          ser_out <= shreg[WORD_W-1];
          shreg   <= shreg << 1;
        end
      end
      default: ;
    endcase
  end

  assert_capture_msb_R2: assert property (@(posedge clk) disable iff (rst)
    (op == ST_STEP && first_bit) |=> (ser_out == $past(par_data[WORD_W-1])));
  assert_hold_data_R5: assert property (@(posedge clk) disable iff (rst)
    (op == ST_HOLD) |=> $stable(ser_out));
  assert_reset_out_R1: assert property (@(posedge clk)
    rst |=> !ser_out);
endmodule

// File: rtl/word_serializer.sv
module word_serializer
  import word_serializer_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic              hold_req,
  input  logic [WORD_W-1:0] par_data,
  output logic              ser_out,
  output logic              frame_clk
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic             hold_q;
  logic [CNT_W-1:0] bit_pos;
  ser_op_e          op;

  ws_hold_sync u_hold (
    .clk      (clk),
    .rst      (rst),
    .hold_req (hold_req),
    .hold_q   (hold_q)
  );

  always_comb begin
    if (rst || sync_i) op = ST_CLEAR;
    else if (hold_q)   op = ST_HOLD;
    else               op = ST_STEP;
  end

  ws_bit_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .bit_pos   (bit_pos),
    .frame_clk (frame_clk)
  );

  ws_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .first_bit (bit_pos == '0),
    .par_data  (par_data),
    .ser_out   (ser_out)
  );

  assert_sync_out_R7: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (!ser_out && !frame_clk));
  assert_release_moves_R6: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && !sync_i && bit_pos == CNT_W'(WORD_W - 1)) |=> (bit_pos == '0));
endmodule

// File: tb/sim_word_serializer.sv
module sim_word_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1, sync_i = 1'b0, hold_req = 1'b0;
  logic [7:0] par_data = 8'h00;
  logic       ser_out, frame_clk;

  int total = 0, bad = 0, cycles = 0;

  logic [2:0] m_cnt = 3'd0;
  logic [7:0] m_sh = 8'h00;
  logic       m_ser = 1'b0, m_frm = 1'b0, m_hold = 1'b0, m_was_held = 1'b0;

  always #5 clk = ~clk;

  word_serializer u0 (
    .clk(clk), .rst(rst), .sync_i(sync_i), .hold_req(hold_req),
    .par_data(par_data), .ser_out(ser_out), .frame_clk(frame_clk)
  );

  function automatic logic exp_frame(input logic [2:0] pos);
    return pos < 3'd4;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic r, input logic s, input logic h, input logic [7:0] d);
    string tag;
    rst = r; sync_i = s; hold_req = h; par_data = d;
    @(negedge clk);
    m_hold = r ? 1'b0 : h;
    @(posedge clk);
    if (r || s) begin
      m_cnt = 3'd0; m_sh = 8'h00; m_ser = 1'b0; m_frm = 1'b0;
      tag = r ? "R1" : "R7";
      m_was_held = 1'b0;
    end else if (m_hold) begin
      tag = "R5";
      m_was_held = 1'b1;
    end else begin
      if (m_cnt == 3'd0) begin
        m_ser = d[7]; m_sh = {d[6:0], 1'b0}; tag = "R2";
      end else begin
        m_ser = m_sh[7]; m_sh = {m_sh[6:0], 1'b0};
        tag = m_was_held ? "R6" : "R3 R8";
      end
      m_frm = exp_frame(m_cnt);
      m_cnt = m_cnt + 3'd1;
      m_was_held = 1'b0;
    end
    #1;
    check(tag, ser_out, m_ser, "ser_out");
    check((tag == "R1" || tag == "R7" || tag == "R5") ? tag : "R4", frame_clk, m_frm, "frame_clk");
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); #2;
    cyc(1, 0, 0, 8'h00);
    cyc(1, 0, 1, 8'hFF);
    // R2 R3 R4: one plain word 0xA5, then 0x3C back to back
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, (i == 0) ? 8'hA5 : 8'h5A);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, (i == 0) ? 8'h3C : 8'hC3);
    // R5 R6: hold in the middle of a word, then release
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, (i == 0) ? 8'hE1 : 8'h00);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 8'hFF);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 8'h00);
    // R7: sync while held, then restart
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, 8'h96);
    cyc(0, 0, 1, 8'h00);
    cyc(0, 1, 1, 8'h00);
    cyc(0, 0, 1, 8'h00);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, (i == 0) ? 8'h81 : 8'h7E);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d = 8'($urandom);
      logic h = ($urandom % 4) == 0;
      logic s = ($urandom % 60) == 0;
      logic r = ($urandom % 400) == 0;
      cyc(r, s, h, d);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule